// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits inside a DRAM controller and owns two jobs: bringing the memory out of power-up, and keeping its contents alive afterwards. Out of reset it keeps RAS and CAS inactive for a programmable pause. It then asks the access arbiter for the bus and, once granted, runs a fixed burst of wake-up refresh cycles before it raises `init_done`. Only from that point may normal accesses begin.

After start-up an interval timer adds one owed refresh every `REF_INTERVAL` clocks. The interval is sized so that the full row count is covered inside the retention period. Owed refreshes are collected in a small saturating counter, so refresh can wait while the access controller finishes a page burst. When the sequencer is granted the bus, it drains every owed refresh with back-to-back cycles, then releases its request. When the counter reaches its ceiling, an urgent flag tells the access controller to close its open row and grant the bus. All refresh cycles use the CAS-first scheme with the DRAM's internal row counter, so this block drives no address. Write enable is left to the controller, which must hold it inactive while this block owns the bus.

The main state machine has six states: PAUSE (timed quiet period), WAKE_REQ (request raised, waiting for the first grant), WAKE_RUN (wake-up burst), IDLE (nothing owed), REQ (owed work, waiting for grant) and RUN (draining owed refreshes). Its transitions are:
- PAUSE to WAKE_REQ when the pause count expires.
- WAKE_REQ to WAKE_RUN on grant.
- WAKE_RUN to IDLE when the last wake-up cycle completes.
- IDLE to REQ when the owed count is non-zero.
- REQ to RUN on grant.
- RUN to IDLE when the owed count is zero and no cycle is in flight.

The cycle engine has five states, visited in a fixed ring: C_IDLE, C_SETUP (CAS low, RAS high), C_HOLD (both low), C_TAIL (RAS low, CAS high), C_PRECH (both high), and back to C_IDLE.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset, `ras_n`, `cas_n` stay high, and `rfsh_req`, `rfsh_urgent`, `init_done` stay low. `rfsh_req` first rises after exactly `PAUSE_CYCLES` clock edges, with no RAS activity before it.
- R2: After the first grant, exactly `WAKE_CYCLES` refresh cycles occur before `init_done` rises. Once high, `init_done` stays high until reset.
- R3: In every refresh cycle `cas_n` goes low first, and stays low for exactly `T_CSR` clocks with `ras_n` high before `ras_n` falls.
- R4: `ras_n` stays low for exactly `T_RAS` clocks per cycle. `cas_n` stays low for exactly `T_CHR` of those clocks and returns high before `ras_n` rises.
- R5: Between back-to-back cycles `ras_n` is high for exactly `T_RP + 1 + T_CSR` clocks (precharge, one idle clock, CAS lead). `cas_n` is high in the clock after `ras_n` rises.
- R6: After `init_done` rises, with no grant given, `rfsh_req` rises exactly `REF_INTERVAL + 1` clock edges later.
- R7: Each elapsed interval adds one owed refresh while the grant is withheld. On grant, exactly that many cycles are run back to back.
- R8: The owed count saturates at `OWE_MAX`. `rfsh_urgent` is high exactly while the count is at `OWE_MAX`, and ticks arriving then are dropped. A grant then runs exactly `OWE_MAX` cycles and clears `rfsh_urgent`.
- R9: `ras_n` or `cas_n` is low only while `rfsh_gnt` is high.
- R10: `rfsh_req` falls exactly `T_RP + 1` clocks after the last `ras_n` rise of a burst, with `ras_n` and `cas_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_gnt | input | 1 | Bus grant from the access arbiter; held while `rfsh_req` is high |
| rfsh_req | output | 1 | Bus request for wake-up or owed refresh cycles |
| rfsh_urgent | output | 1 | Owed count at ceiling; the access controller must close its row |
| init_done | output | 1 | Pause and wake-up burst complete; normal access allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The bench builds the block with a 50-clock pause, 8 wake-up cycles, a 60-clock refresh interval and an owed ceiling of 4. It uses strobe timings of 2, 2, 5 and 3 clocks. These values put saturation within a few hundred clocks, and they keep a full ceiling's worth of back-to-back cycles shorter than one interval, so the bench can state owed counts exactly. The bench withholds and later gives the grant at chosen points in the interval. This lets it observe accumulation, saturation with dropped ticks, and the release point of the request, while a monitor measures every strobe phase of every cycle.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        M_PAUSE,
        M_WAKE_REQ,
        M_WAKE_RUN,
        M_IDLE,
        M_REQ,
        M_RUN
    } main_st_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_SETUP,
        C_HOLD,
        C_TAIL,
        C_PRECH
    } cyc_st_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
    parameter int MAX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       add,
    input  logic                       sub,
    output logic [$clog2(MAX+1)-1:0]   owed,
    output logic                       nonzero,
    output logic                       full
);
    localparam int CW = $clog2(MAX + 1);
    localparam logic [CW-1:0] CEIL = CW'(MAX);

    logic [CW-1:0] owed_q;
    logic          inc;
    logic          dec;

    // A tick arriving at the ceiling is dropped; a completion always counts.
    assign inc = add && (owed_q != CEIL);
    assign dec = sub && (owed_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    assign owed    = owed_q;
    assign nonzero = (owed_q != '0);
    assign full    = (owed_q == CEIL);
endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
    import dram_rfsh_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_CHR = 1,
    parameter int T_RAS = 6,
    parameter int T_RP  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXT = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] L_CSR  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_CHR  = CW'(T_CHR - 1);
    localparam logic [CW-1:0] L_TAIL = CW'(T_RAS - T_CHR - 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);

    cyc_st_t       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expired;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= C_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = expired ? '0 : cnt_q - 1'b1;
        unique case (st_q)
            C_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    st_d  = C_SETUP;
                    cnt_d = L_CSR;
                end
            end
            C_SETUP: if (expired) begin
                st_d  = C_HOLD;
                cnt_d = L_CHR;
            end
            C_HOLD: if (expired) begin
                st_d  = C_TAIL;
                cnt_d = L_TAIL;
            end
            C_TAIL: if (expired) begin
                st_d  = C_PRECH;
                cnt_d = L_RP;
            end
            C_PRECH: if (expired) begin
                st_d  = C_IDLE;
                cnt_d = '0;
            end
            default: begin
                st_d  = C_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        cas_n = 1'b1;
        ras_n = 1'b1;
        idle  = 1'b0;
        done  = 1'b0;
        unique case (st_q)
            C_IDLE:  idle = 1'b1;
            C_SETUP: cas_n = 1'b0;
            C_HOLD: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            C_TAIL:  ras_n = 1'b0;
            C_PRECH: done = expired;
            default: idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYCLES = 20000,
    parameter int WAKE_CYCLES  = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int OWE_MAX      = 8,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic rfsh_urgent,
    output logic init_done,
    output logic ras_n,
    output logic cas_n
);
    localparam int PW = $clog2(PAUSE_CYCLES + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);
    localparam int OW = $clog2(OWE_MAX + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
    localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_CYCLES - 1);

    main_st_t      st_q, st_d;
    logic [PW-1:0] pause_q;
    logic [WW-1:0] wake_q;
    logic          cyc_start, cyc_idle, cyc_done;
    logic          tick, owed_nz, owed_full;
    logic [OW-1:0] owed;
    logic          debt_sub;

    // State register and its counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= M_PAUSE;
            pause_q <= '0;
            wake_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == M_PAUSE && pause_q != PAUSE_LAST) begin
                pause_q <= pause_q + 1'b1;
            end
            if (st_q == M_WAKE_RUN && cyc_done) begin
                wake_q <= wake_q + 1'b1;
            end
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            M_PAUSE:    if (pause_q == PAUSE_LAST) st_d = M_WAKE_REQ;
            M_WAKE_REQ: if (rfsh_gnt) st_d = M_WAKE_RUN;
            M_WAKE_RUN: if (cyc_done && wake_q == WAKE_LAST) st_d = M_IDLE;
            M_IDLE:     if (owed_nz) st_d = M_REQ;
            M_REQ:      if (rfsh_gnt) st_d = M_RUN;
            M_RUN:      if (cyc_idle && !owed_nz) st_d = M_IDLE;
            default:    st_d = M_PAUSE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        rfsh_req  = 1'b0;
        init_done = 1'b0;
        cyc_start = 1'b0;
        debt_sub  = 1'b0;
        unique case (st_q)
            M_PAUSE: ;
            M_WAKE_REQ: rfsh_req = 1'b1;
            M_WAKE_RUN: begin
                rfsh_req  = 1'b1;
                cyc_start = cyc_idle && rfsh_gnt;
            end
            M_IDLE: init_done = 1'b1;
            M_REQ: begin
                init_done = 1'b1;
                rfsh_req  = 1'b1;
            end
            M_RUN: begin
                init_done = 1'b1;
                rfsh_req  = 1'b1;
                cyc_start = cyc_idle && rfsh_gnt && owed_nz;
                debt_sub  = cyc_done;
            end
            default: ;
        endcase
    end

    assign rfsh_urgent = owed_full;

    rfsh_interval_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    rfsh_debt_counter #(
        .MAX (OWE_MAX)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (tick),
        .sub     (debt_sub),
        .owed    (owed),
        .nonzero (owed_nz),
        .full    (owed_full)
    );

    cbr_cycle_engine #(
        .T_CSR (T_CSR),
        .T_CHR (T_CHR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .idle  (cyc_idle),
        .done  (cyc_done),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rfsh_gnt,
    input logic rfsh_req,
    input logic rfsh_urgent,
    input logic init_done,
    input logic ras_n,
    input logic cas_n
);
    AST_QUIET_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !rfsh_req) |-> (ras_n && cas_n)); // R1

    AST_INIT_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R2

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n))); // R3

    AST_CAS_UP_AT_RAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n); // R4

    AST_CAS_HIGH_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> cas_n); // R5

    AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_urgent |-> (rfsh_req && init_done)); // R8

    AST_STROBES_NEED_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> rfsh_gnt); // R9

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rfsh_req) && init_done) |-> (ras_n && cas_n)); // R10
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rfsh_gnt    (rfsh_gnt),
    .rfsh_req    (rfsh_req),
    .rfsh_urgent (rfsh_urgent),
    .init_done   (init_done),
    .ras_n       (ras_n),
    .cas_n       (cas_n)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE = 50;
    localparam int WAKE  = 8;
    localparam int IVL   = 60;
    localparam int OWE   = 4;
    localparam int TCSR  = 2;
    localparam int TCHR  = 2;
    localparam int TRAS  = 5;
    localparam int TRP   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, urgent, idone, ras_n, cas_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit auto_gnt = 1'b0;
    bit manual_gnt = 1'b0;
    bit finished = 1'b0;

    // monitor state
    int ras_falls = 0;
    int lead = 0, low_len = 0, hold = 0, high_len = 0;
    int lead_bad = 0, width_bad = 0, hold_bad = 0, nogrant_bad = 0;
    int gap_min = 1000000;
    int rise_cyc = 0;
    bit seen_fall = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    dram_refresh_seq #(
        .PAUSE_CYCLES (PAUSE),
        .WAKE_CYCLES  (WAKE),
        .REF_INTERVAL (IVL),
        .OWE_MAX      (OWE),
        .T_CSR        (TCSR),
        .T_CHR        (TCHR),
        .T_RAS        (TRAS),
        .T_RP         (TRP)
    ) i_dram_refresh_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rfsh_gnt    (gnt),
        .rfsh_req    (req),
        .rfsh_urgent (urgent),
        .init_done   (idone),
        .ras_n       (ras_n),
        .cas_n       (cas_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) gnt <= auto_gnt ? req : manual_gnt;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((!ras_n || !cas_n) && !gnt) nogrant_bad++;
            if (ras_n) begin
                if (!prev_ras) begin
                    if (low_len != TRAS) width_bad++;
                    if (!cas_n) hold_bad++;
                    high_len = 0;
                    rise_cyc = cyc;
                end
                high_len++;
                if (!cas_n) lead++;
                else lead = 0;
            end else begin
                if (prev_ras) begin
                    ras_falls++;
                    if (lead != TCSR) lead_bad++;
                    if (seen_fall && high_len < gap_min) gap_min = high_len;
                    seen_fall = 1'b1;
                    lead = 0;
                    low_len = 0;
                    hold = 0;
                end
                low_len++;
                if (!cas_n) hold++;
                else if (!prev_cas && hold != TCHR) hold_bad++;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_level(input bit want_req);
        while (req !== want_req) @(negedge clk);
    endtask

    int t_done = 0;

    task automatic t_reset_state();
        rst_n = 1'b0;
        wait_cycles(3);
        chk("R1", int'(ras_n), 1, "ras_n in reset");
        chk("R1", int'(cas_n), 1, "cas_n in reset");
        chk("R1", int'(req), 0, "req in reset");
        chk("R1", int'(idone), 0, "init_done in reset");
        chk("R8", int'(urgent), 0, "urgent in reset");
    endtask

    task automatic t_pause_and_wake();
        int t0, f0;
        auto_gnt = 1'b1;
        t0 = cyc;
        rst_n = 1'b1;
        @(negedge clk);
        wait_level(1'b1);
        chk("R1", cyc - t0, PAUSE, "edges until first request");
        chk("R1", ras_falls, 0, "RAS activity during pause");
        f0 = ras_falls;
        while (idone !== 1'b1) @(negedge clk);
        t_done = cyc;
        chk("R2", ras_falls - f0, WAKE, "wake-up cycles before init_done");
    endtask

    task automatic t_periodic();
        int f0;
        auto_gnt = 1'b0;
        manual_gnt = 1'b0;
        @(negedge clk);
        wait_level(1'b1);
        chk("R6", cyc - t_done, IVL + 1, "edges from init_done to request");
        f0 = ras_falls;
        auto_gnt = 1'b1;
        wait_level(1'b0);
        chk("R7", ras_falls - f0, 1, "cycles for a single owed refresh");
        chk("R10", cyc - rise_cyc, TRP + 1, "request release after last RAS rise");
        chk("R10", int'(ras_n && cas_n), 1, "strobes idle at release");
        auto_gnt = 1'b0;
    endtask

    task automatic t_owed();
        int f0;
        manual_gnt = 1'b0;
        wait_level(1'b1);
        f0 = ras_falls;
        wait_cycles(2 * IVL + 2);
        chk("R9", ras_falls - f0, 0, "cycles without grant");
        chk("R8", int'(urgent), 0, "urgent below ceiling");
        manual_gnt = 1'b1;
        @(negedge clk);
        wait_level(1'b0);
        manual_gnt = 1'b0;
        chk("R7", ras_falls - f0, 3, "cycles for three owed refreshes");
        chk("R5", gap_min, TRP + 1 + TCSR, "RAS high between back-to-back cycles");
    endtask

    task automatic t_saturate();
        int f0;
        manual_gnt = 1'b0;
        wait_level(1'b1);
        f0 = ras_falls;
        wait_cycles(2 * IVL + 2);
        chk("R8", int'(urgent), 0, "urgent with three owed");
        wait_cycles(IVL);
        chk("R8", int'(urgent), 1, "urgent at ceiling");
        wait_cycles(3 * IVL);
        chk("R8", int'(urgent), 1, "urgent held while ticks drop");
        manual_gnt = 1'b1;
        @(negedge clk);
        wait_level(1'b0);
        manual_gnt = 1'b0;
        chk("R8", ras_falls - f0, OWE, "cycles after saturation");
        chk("R8", int'(urgent), 0, "urgent after drain");
    endtask

    task automatic t_timing_summary();
        chk("R3", lead_bad, 0, "cycles with wrong CAS lead");
        chk("R4", width_bad, 0, "cycles with wrong RAS low width");
        chk("R4", hold_bad, 0, "cycles with wrong CAS hold");
        chk("R9", nogrant_bad, 0, "strobe samples without grant");
        chk("R2", int'(idone), 1, "init_done still high");
    endtask

    initial begin
        t_reset_state();
        t_pause_and_wake();
        t_periodic();
        t_owed();
        t_saturate();
        t_timing_summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule